// File: doc/BRIEF.md
# Phase-Configurable Serial Flash Transaction Engine

This block is a serial-peripheral master that runs one complete flash transaction per start pulse. The transaction is built from a chosen set of phases: an 8-bit opcode, an optional 3- or 4-byte address, and an optional outgoing or incoming payload whose byte count is programmable. Outgoing payload bytes are read from a small internal byte buffer. Incoming bytes are written back into the same buffer. A host port loads and reads that buffer between transactions.

A separate status-poll mode sends the read-status opcode and then keeps clocking status bytes until the device reports not-busy. If the device stays busy past a programmable number of reads, the poll gives up and raises an error. The serial clock is produced from the system clock by a 16-bit divider. Framing is clock-idle-low, data launched on the falling edge and sampled on the rising edge, most significant bit first, with an active-low select.

Top module: `sflash_xact_engine`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `done`, `busy` and `timeout_err` are 0.
- R2: While `cs_n` is 1, `sclk` stays 0. `mosi` changes only while `sclk` is low, so it is stable at each rising edge. Each byte goes out MSB first, and the opcode byte is always the first byte of a transaction.
- R3: `mode` selects the phases: 0 = opcode only, 1 = opcode+address, 2 = opcode+data-out, 3 = opcode+address+data-out, 4 = opcode+data-in, 5 = opcode+address+data-in, 6 and 7 = status poll. The byte count on the wire is 1 + address bytes + payload bytes.
- R4: With `addr_wide` = 0, the address phase sends `addr[23:16]`, `addr[15:8]`, `addr[7:0]`. With `addr_wide` = 1 it sends `addr[31:24]` first, then those same three bytes.
- R5: In a data-out phase, `len` bytes are sent from buffer entries 0 .. len-1 in ascending order.
- R6: In a data-in phase, `mosi` is held at 0. The byte received in payload position i is written to buffer entry i, and entries from `len` upward are left unchanged.
- R7: A `len` of 0 behaves as if the mode had no data phase.
- R8: `done` goes to 1 on the same clock edge on which `cs_n` returns to 1. An accepted start clears `done` on the next edge and raises `busy`. `busy` is 1 whenever `cs_n` is 0.
- R9: In poll mode the engine sends opcode 0x05 and then reads status bytes until one arrives with bit 0 clear. That last byte is shown on `poll_status`, and `timeout_err` stays 0.
- R10: If `POLL_LIMIT` status bytes in a row all have bit 0 set, the transaction ends with `timeout_err` = 1, and `poll_status` shows the last byte.
- R11: A start pulse while `busy` is 1 is ignored: it starts no further transaction and does not change the one in progress.
- R12: Within a byte, consecutive rising edges of `sclk` are 2*(clk_div+1) system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| mode | input | 3 | Phase combination select |
| addr_wide | input | 1 | 1 = four address bytes, 0 = three |
| cmd | input | 8 | Opcode byte |
| addr | input | 32 | Address, byte 0 least significant |
| len | input | 16 | Payload byte count |
| clk_div | input | 16 | Serial half-period minus one, in system clocks |
| host_wr_en | input | 1 | Host buffer write strobe |
| host_addr | input | $clog2(BUF_DEPTH) | Host buffer entry index |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Buffer entry at `host_addr` |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last transaction finished |
| timeout_err | output | 1 | Last poll ran out of reads |
| poll_status | output | 8 | Last status byte received in poll mode |

## Verification
A wrong phase or byte counter shows up at the pins within the same transaction. It appears as a missing or extra group of eight `sclk` rising edges, a misordered address byte, or a payload byte landing in the wrong buffer entry. A divider or shifter fault changes the spacing of the very first pair of rising edges after the select falls. A fault in the poll counter or the busy-bit test changes how many status bytes are clocked before `cs_n` rises, and whether `timeout_err` is set. A sequencer that fails to return to idle keeps `cs_n` low, or never raises `done`, and the bench's completion wait catches this.

// File: rtl/sfx_pkg.sv
// Shared types for the serial flash transaction engine.
// Assumes: mode bit 0 selects an address phase; bits 2:1 select the data kind.
package sfx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DOUT,
        ST_DIN,
        ST_PCMD,
        ST_PRD
    } sfx_state_e;

    localparam logic [1:0] DK_NONE = 2'b00;
    localparam logic [1:0] DK_OUT  = 2'b01;
    localparam logic [1:0] DK_IN   = 2'b10;
    localparam logic [1:0] DK_POLL = 2'b11;

    localparam logic [7:0] OPC_READ_STATUS = 8'h05;
endpackage

// File: rtl/sfx_divider.sv
// Half-period tick generator for the serial clock.
// Assumes: restart arrives in the cycle a byte is loaded; a tick fires once
// every div+1 cycles while enabled.
module sfx_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div);

    // Count system cycles within one serial half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sfx_shifter.sv
// One-byte serial shifter: clock idles low, launches on falling edge,
// samples on rising edge, MSB first.
// Assumes: go is only honoured while idle; tick paces each half period.
module sfx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [CNT_W-1:0]  bit_q;

    assign mosi    = tx_q[BYTE_W-1];
    assign rx_byte = rx_q;

    // Shift one byte out and one byte in, toggling sclk on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            rx_q      <= '0;
            bit_q     <= '0;
            sclk      <= 1'b0;
            active    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (go && !active) begin
                tx_q   <= tx_byte;
                bit_q  <= '0;
                sclk   <= 1'b0;
                active <= 1'b1;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx_q <= {rx_q[BYTE_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == LAST_BIT) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sfx_bytebuf.sv
// Payload byte buffer: one write port, two combinational read ports.
// Assumes: the caller muxes engine and host writes onto the single port.
module sfx_bytebuf #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_a,
    output logic [7:0]               rd_data_a,
    input  logic [$clog2(DEPTH)-1:0] rd_addr_b,
    output logic [7:0]               rd_data_b
);
    logic [7:0] mem [DEPTH];

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end
endmodule

// File: rtl/sfx_sequencer.sv
// Phase sequencer: walks opcode, address, payload or status-poll phases and
// owns chip select, done, timeout and the buffer pointer.
// Assumes: the shifter raises byte_done for one cycle per finished byte and
// accepts go one cycle later.
module sfx_sequencer
    import sfx_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int BUF_AW     = 4,
    parameter int POLL_LIMIT = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        mode,
    input  logic              addr_wide,
    input  logic [7:0]        cmd,
    input  logic [31:0]       addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rd_data,
    output logic [BUF_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [BUF_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              go,
    output logic [7:0]        tx_byte,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [7:0]        poll_status
);
    localparam int PC_W = $clog2(POLL_LIMIT + 1);
    localparam logic [PC_W-1:0] POLL_LAST = PC_W'(POLL_LIMIT - 1);

    sfx_state_e       state_q;
    logic [2:0]       mode_q;
    logic             wide_q;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [1:0]       aidx_q;
    logic [PC_W-1:0]  pcnt_q;

    logic [LEN_W-1:0] cnt_nx;
    logic [1:0]       aidx_nx;
    logic [1:0]       dkind;
    logic             len_zero;

    assign cnt_nx   = cnt_q + 1'b1;
    assign aidx_nx  = aidx_q - 2'd1;
    assign dkind    = mode_q[2:1];
    assign len_zero = (len_q == '0);
    assign busy     = (state_q != ST_IDLE);

    // Buffer pointer: next outgoing byte while streaming, else entry 0.
    always_comb begin
        rd_addr = '0;
        if (state_q == ST_DOUT) begin
            rd_addr = cnt_nx[BUF_AW-1:0];
        end
    end

    // Capture each incoming payload byte into the buffer.
    always_comb begin
        wr_en   = (state_q == ST_DIN) && byte_done;
        wr_addr = cnt_q[BUF_AW-1:0];
        wr_data = rx_byte;
    end

    // Phase state machine and chip-select control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= '0;
            wide_q      <= 1'b0;
            addr_q      <= '0;
            len_q       <= '0;
            cnt_q       <= '0;
            aidx_q      <= '0;
            pcnt_q      <= '0;
            go          <= 1'b0;
            tx_byte     <= '0;
            cs_n        <= 1'b1;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            poll_status <= '0;
        end else begin
            go <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q      <= mode;
                        wide_q      <= addr_wide;
                        addr_q      <= addr;
                        len_q       <= len;
                        cnt_q       <= '0;
                        pcnt_q      <= '0;
                        done        <= 1'b0;
                        timeout_err <= 1'b0;
                        cs_n        <= 1'b0;
                        go          <= 1'b1;
                        if (mode[2:1] == DK_POLL) begin
                            tx_byte <= OPC_READ_STATUS;
                            state_q <= ST_PCMD;
                        end else begin
                            tx_byte <= cmd;
                            state_q <= ST_CMD;
                        end
                    end
                end
                ST_CMD, ST_ADDR: begin
                    if (byte_done) begin
                        if (state_q == ST_CMD && mode_q[0]) begin
                            state_q <= ST_ADDR;
                            aidx_q  <= wide_q ? 2'd3 : 2'd2;
                            tx_byte <= wide_q ? addr_q[31:24] : addr_q[23:16];
                            go      <= 1'b1;
                        end else if (state_q == ST_ADDR && aidx_q != 2'd0) begin
                            aidx_q  <= aidx_nx;
                            tx_byte <= addr_q[{aidx_nx, 3'b000} +: 8];
                            go      <= 1'b1;
                        end else if (dkind == DK_OUT && !len_zero) begin
                            state_q <= ST_DOUT;
                            tx_byte <= rd_data;
                            go      <= 1'b1;
                        end else if (dkind == DK_IN && !len_zero) begin
                            state_q <= ST_DIN;
                            tx_byte <= '0;
                            go      <= 1'b1;
                        end else begin
                            state_q <= ST_IDLE;
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                        end
                    end
                end
                ST_DOUT, ST_DIN: begin
                    if (byte_done) begin
                        cnt_q <= cnt_nx;
                        if (cnt_nx == len_q) begin
                            state_q <= ST_IDLE;
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            tx_byte <= (state_q == ST_DOUT) ? rd_data : 8'h00;
                            go      <= 1'b1;
                        end
                    end
                end
                ST_PCMD: begin
                    if (byte_done) begin
                        state_q <= ST_PRD;
                        tx_byte <= '0;
                        go      <= 1'b1;
                    end
                end
                ST_PRD: begin
                    if (byte_done) begin
                        poll_status <= rx_byte;
                        if (!rx_byte[0]) begin
                            state_q <= ST_IDLE;
                            cs_n    <= 1'b1;
                            done    <= 1'b1;
                        end else if (pcnt_q == POLL_LAST) begin
                            state_q     <= ST_IDLE;
                            cs_n        <= 1'b1;
                            done        <= 1'b1;
                            timeout_err <= 1'b1;
                        end else begin
                            pcnt_q  <= pcnt_q + 1'b1;
                            tx_byte <= '0;
                            go      <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sflash_xact_engine.sv
// Top level: wires divider, shifter, sequencer and payload buffer.
// Assumes: the host touches the buffer only while busy is low.
module sflash_xact_engine #(
    parameter int BUF_DEPTH  = 16,
    parameter int LEN_W      = 16,
    parameter int DIV_W      = 16,
    parameter int POLL_LIMIT = 65535
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [2:0]                   mode,
    input  logic                         addr_wide,
    input  logic [7:0]                   cmd,
    input  logic [31:0]                  addr,
    input  logic [LEN_W-1:0]             len,
    input  logic [DIV_W-1:0]             clk_div,
    input  logic                         host_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] host_addr,
    input  logic [7:0]                   host_wdata,
    output logic [7:0]                   host_rdata,
    output logic                         sclk,
    output logic                         cs_n,
    output logic                         mosi,
    input  logic                         miso,
    output logic                         busy,
    output logic                         done,
    output logic                         timeout_err,
    output logic [7:0]                   poll_status
);
    localparam int BUF_AW = $clog2(BUF_DEPTH);

    logic              tick;
    logic              go;
    logic              active;
    logic              byte_done;
    logic [7:0]        tx_byte;
    logic [7:0]        rx_byte;
    logic [BUF_AW-1:0] eng_rd_addr;
    logic [7:0]        eng_rd_data;
    logic              eng_wr_en;
    logic [BUF_AW-1:0] eng_wr_addr;
    logic [7:0]        eng_wr_data;
    logic              mem_wr_en;
    logic [BUF_AW-1:0] mem_wr_addr;
    logic [7:0]        mem_wr_data;

    // Engine writes take the buffer port ahead of host writes.
    always_comb begin
        mem_wr_en   = eng_wr_en || host_wr_en;
        mem_wr_addr = eng_wr_en ? eng_wr_addr : host_addr;
        mem_wr_data = eng_wr_en ? eng_wr_data : host_wdata;
    end

    sfx_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (active),
        .restart (go),
        .div     (clk_div),
        .tick    (tick)
    );

    sfx_shifter #(.BYTE_W(8)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .go        (go),
        .tx_byte   (tx_byte),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .active    (active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    sfx_sequencer #(
        .LEN_W      (LEN_W),
        .BUF_AW     (BUF_AW),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode        (mode),
        .addr_wide   (addr_wide),
        .cmd         (cmd),
        .addr        (addr),
        .len         (len),
        .byte_done   (byte_done),
        .rx_byte     (rx_byte),
        .rd_data     (eng_rd_data),
        .rd_addr     (eng_rd_addr),
        .wr_en       (eng_wr_en),
        .wr_addr     (eng_wr_addr),
        .wr_data     (eng_wr_data),
        .go          (go),
        .tx_byte     (tx_byte),
        .cs_n        (cs_n),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err),
        .poll_status (poll_status)
    );

    sfx_bytebuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk       (clk),
        .wr_en     (mem_wr_en),
        .wr_addr   (mem_wr_addr),
        .wr_data   (mem_wr_data),
        .rd_addr_a (eng_rd_addr),
        .rd_data_a (eng_rd_data),
        .rd_addr_b (host_addr),
        .rd_data_b (host_rdata)
    );
endmodule

// File: rtl/sflash_xact_engine_chk.sv
// Protocol checker for the transaction engine, bound to the top level.
// Assumes: synchronous active-low reset; all checks sample on clk.
module sflash_xact_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic done,
    input logic timeout_err
);
    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_mosi_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    p_done_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    p_busy_when_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_done_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!done && busy));

    p_err_ends_txn_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (done && cs_n));
endmodule

bind sflash_xact_engine sflash_xact_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sclk        (sclk),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/sflash_xact_engine_tb.sv
module sflash_xact_engine_tb;
    localparam int DEPTH = 16;
    localparam int PLIM  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic        addr_wide = 1'b0;
    logic [7:0]  cmd = '0;
    logic [31:0] addr = '0;
    logic [15:0] len = '0;
    logic [15:0] clk_div = 16'd1;
    logic        host_wr_en = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        sclk, cs_n, mosi, miso;
    logic        busy, done, timeout_err;
    logic [7:0]  poll_status;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sflash_xact_engine #(.BUF_DEPTH(DEPTH), .POLL_LIMIT(PLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_wide(addr_wide), .cmd(cmd), .addr(addr), .len(len),
        .clk_div(clk_div), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy), .done(done),
        .timeout_err(timeout_err), .poll_status(poll_status)
    );

    // ---------------- flash slave model ----------------
    int         resp_kind = 0;
    int         k = 0, b = 0, last_k = 0, cs_falls = 0;
    int         rise_t [2];
    logic [7:0] rec [DEPTH];
    logic [7:0] cur = '0;
    logic [7:0] nxt;
    logic [7:0] cur_resp;

    function automatic logic [7:0] resp_of(int kind, int kk);
        if (kind == 0) return 8'hC3 ^ 8'(kk * 29);
        if (kind == 1) return (kk == 1) ? 8'h03 : (kk == 2) ? 8'h01 : 8'h00;
        return 8'h81;
    endfunction

    assign cur_resp = resp_of(resp_kind, k);
    assign miso = cur_resp[3'(7 - b)];

    always @(negedge cs_n) cs_falls <= cs_falls + 1;

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            last_k <= k;
            k <= 0;
            b <= 0;
        end else begin
            if (k == 0 && b < 2) rise_t[b] <= cyc;
            nxt = {cur[6:0], mosi};
            cur <= nxt;
            if (b == 7) begin
                if (k < DEPTH) rec[k] <= nxt;
                k <= k + 1;
                b <= 0;
            end else begin
                b <= b + 1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            host_wr_en = 1'b1; host_addr = 4'(i); host_wdata = 8'(8'h30 + i);
        end
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int  n = 0;
        logic prev_cs = cs_n;
        chk(busy === 1'b1 && done === 1'b0, "R8", "busy/done after start",
            {busy, done}, 2'b10);
        while (done !== 1'b1 && n < 20000) begin
            prev_cs = cs_n;
            @(negedge clk);
            n++;
        end
        chk(n < 20000, req, "completion", n, 0);
        chk(cs_n === 1'b1 && prev_cs === 1'b0, "R8", "done with cs release",
            {cs_n, prev_cs}, 2'b10);
        @(negedge clk);
    endtask

    task automatic run_txn(input logic [2:0] m, input logic w, input logic [7:0] c,
                           input logic [31:0] a, input logic [15:0] l);
        int na, nd, exp_k, idx;
        logic [7:0] e;
        bit ok;
        preload();
        resp_kind = 0;
        mode = m; addr_wide = w; cmd = c; addr = a; len = l;
        pulse_start();
        wait_done("R3");
        na = m[0] ? (w ? 4 : 3) : 0;
        nd = (m[2:1] == 2'b01 || m[2:1] == 2'b10) ? int'(l) : 0;   // R7: len 0 => none
        exp_k = 1 + na + nd;
        chk(last_k == exp_k, "R3", "byte count", last_k, exp_k);
        chk(rec[0] == c, "R2", "opcode first", rec[0], c);
        ok = 1'b1;
        for (int i = 0; i < na; i++) begin
            e = a[8*(na-1-i) +: 8];
            if (rec[1+i] !== e) ok = 1'b0;
        end
        chk(ok, "R4", "address order", m, w);
        ok = 1'b1;
        for (int i = 0; i < nd; i++) begin
            idx = 1 + na + i;
            e = (m[2:1] == 2'b01) ? 8'(8'h30 + i) : 8'h00;
            if (rec[idx] !== e) ok = 1'b0;
        end
        chk(ok, (m[2:1] == 2'b01) ? "R5" : "R6", "payload on mosi", m, l);
        if (m[2:1] == 2'b10) begin
            ok = 1'b1;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                host_addr = 4'(i);
                #1;
                e = (i < int'(l)) ? resp_of(0, 1 + na + i) : 8'(8'h30 + i);
                if (host_rdata !== e) ok = 1'b0;
            end
            chk(ok, "R6", "buffer after read", l, na);
        end
        chk(timeout_err === 1'b0, "R8", "no error", timeout_err, 0);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int lens [3] = '{0, 1, 3};
        int falls0, period;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_n === 1 && sclk === 0 && done === 0 && busy === 0 && timeout_err === 0,
            "R1", "reset state", {cs_n, sclk, done, busy, timeout_err}, 5'b10000);

        // R3 R4 R5 R6 R7 sweep over all data modes, widths and lengths
        clk_div = 16'd1;
        for (int m = 0; m < 6; m++)
            for (int w = 0; w < 2; w++)
                for (int li = 0; li < 3; li++)
                    run_txn(3'(m), w[0], 8'(8'h90 + m * 7 + li),
                            32'hA1B2C3D4 ^ (32'(m) << (8 * li)), 16'(lens[li]));

        // R12 divider spacing
        for (int d = 0; d < 4; d += 3) begin
            clk_div = 16'(d);
            run_txn(3'd0, 1'b0, 8'h5A, 32'h0, 16'd0);
            period = rise_t[1] - rise_t[0];
            chk(period == 2 * (d + 1), "R12", "sclk period", period, 2 * (d + 1));
        end
        clk_div = 16'd1;

        // R9 poll until ready
        resp_kind = 1; mode = 3'd6; cmd = 8'hEE;
        pulse_start();
        wait_done("R9");
        chk(last_k == 4, "R9", "poll byte count", last_k, 4);
        chk(rec[0] == 8'h05, "R9", "poll opcode", rec[0], 8'h05);
        chk(poll_status == 8'h00 && timeout_err == 1'b0, "R9", "poll result",
            {poll_status, timeout_err}, 0);

        // R10 poll timeout
        resp_kind = 2; mode = 3'd7;
        pulse_start();
        wait_done("R10");
        chk(last_k == 1 + PLIM, "R10", "timeout byte count", last_k, 1 + PLIM);
        chk(timeout_err === 1'b1 && poll_status == 8'h81, "R10", "timeout flag",
            {poll_status, timeout_err}, {8'h81, 1'b1});

        // R11 start ignored while busy
        resp_kind = 0; clk_div = 16'd3;
        falls0 = cs_falls;
        mode = 3'd0; cmd = 8'hA1; len = 16'd0;
        pulse_start();
        repeat (5) @(negedge clk);
        mode = 3'd2; cmd = 8'h55; len = 16'd3;
        pulse_start();
        wait_done("R11");
        repeat (40) @(negedge clk);
        chk(last_k == 1 && rec[0] == 8'hA1, "R11", "txn unchanged", rec[0], 8'hA1);
        chk(cs_falls - falls0 == 1 && cs_n === 1'b1, "R11", "no extra txn",
            cs_falls - falls0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule